// File: doc/BRIEF.md
# Spindle Speed Frequency-Locked Loop

This block holds a spindle motor at a programmed speed by comparing the time between feedback events with a target period. Both are counted in system clocks. The target is loaded from two fields. The coarse field counts blocks of 2^PRE_LOG2 clocks. The fine field counts single clocks and runs after the coarse field has expired. Each feedback event closes one sample and starts counting a new target.

When a sample closes before the target has run out, the motor is too fast, and the block emits a down pulse for the clocks still left. When the target runs out first, an up pulse runs from that moment until the sample closes. Both pulses are capped at 2^SAT_LOG2 clocks and drive an external charge pump and loop filter. The feedback source can be one of three:
- each commutation tick (one electrical cycle);
- every fourth or sixth tick (one mechanical revolution of an 8- or 12-pole motor);
- the rising edge of an external index input.

Two override inputs force the pump in either direction. A lock flag reports whether the samples stay within a maximum interval. A cycle output shows either the raw zero-crossing level or a square wave that toggles once per internal cycle.

Top module: `spindle_fll`

## Requirements
- R1: After reset, pump_up, pump_dn and lock_ok are 0. No pump pulse appears until the first feedback event after reset has started a measurement.
- R2: The target is T = coarse_tgt*2^PRE_LOG2 + fine_tgt clocks. A sample of k clocks with k < T gives a pump_dn pulse of T-k clocks, starting in the cycle after the closing event. A sample with k == T gives no pulse.
- R3: A sample of k clocks with k > T gives a pump_up pulse of k-T clocks. It starts in the cycle after the target expires and ends when the closing event is seen.
- R4: Both pulse kinds are limited to 2^SAT_LOG2 clocks. If no further event arrives, pump_up drops after 2^SAT_LOG2 clocks and stays low.
- R5: pump_up and pump_dn are never 1 in the same cycle.
- R6: With elec_sel=1 and ext_sel=0, every cycle in which comm_tick is 1 closes a sample.
- R7: With elec_sel=0 and ext_sel=0, only every 4th comm_tick (pole8=1) or every 6th comm_tick (pole8=0) closes a sample. Ticks are counted from reset.
- R8: With ext_sel=1, a 0-to-1 change of index_in closes a sample, and comm_tick has no effect on the pump outputs.
- R9: force_up alone gives pump_up=1 and pump_dn=0. force_dn alone gives pump_dn=1 and pump_up=0. Both together give 0 on both outputs. With neither set, the loop drives the outputs.
- R10: lock_ok becomes 0 in the cycle in which LOCK_LIMIT+1 clocks have passed without an event. A closing event sets it to 1 if its interval was at most LOCK_LIMIT clocks, and to 0 otherwise.
- R11: With cyc_sel=0, cyc_out follows zc_in. With cyc_sel=1, cyc_out is a level that is 0 after reset and inverts on each internal cycle of R6/R7, whatever ext_sel is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coarse_tgt | input | COARSE_W | Target part counted in blocks of 2^PRE_LOG2 clocks |
| fine_tgt | input | FINE_W | Target part counted in single clocks |
| elec_sel | input | 1 | 1: sample per electrical cycle, 0: per mechanical revolution |
| ext_sel | input | 1 | 1: samples closed by index_in edges |
| pole8 | input | 1 | 1: 4 ticks per revolution, 0: 6 ticks |
| force_up | input | 1 | Override forcing the up output |
| force_dn | input | 1 | Override forcing the down output |
| cyc_sel | input | 1 | Cycle output select: 1 cycle toggle, 0 raw zero-crossing |
| comm_tick | input | 1 | One-cycle strobe per electrical cycle |
| index_in | input | 1 | External index level, rising edge used |
| zc_in | input | 1 | Raw zero-crossing level |
| pump_up | output | 1 | Charge-pump up pulse |
| pump_dn | output | 1 | Charge-pump down pulse |
| cyc_out | output | 1 | Selected cycle signal |
| lock_ok | output | 1 | 1 while sample intervals stay within LOCK_LIMIT |

## Verification
Several properties are checked on every cycle:
- the two pump outputs are never high together;
- a running down pulse loses exactly one clock per cycle;
- the up-width counter advances every cycle until it saturates;
- lock_ok falls once the interval counter reaches its limit;
- the revolution tick counter stays in range;
- comm_tick cannot start a measurement in index mode.

Exact pulse widths relative to the target can only be shown by the bench scenarios. The same holds for the k==T case, saturation in both directions, and the selection of electrical, mechanical and index feedback. The bench also covers the override combinations, the lock boundary at exactly LOCK_LIMIT and LOCK_LIMIT+1 clocks, and the cycle output.

// File: rtl/spindle_fll.sv
module spindle_fll #(
  parameter int COARSE_W   = 12,
  parameter int FINE_W     = 11,
  parameter int PRE_LOG2   = 11,
  parameter int SAT_LOG2   = 16,
  parameter int LOCK_LIMIT = 400000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [COARSE_W-1:0] coarse_tgt,
  input  logic [FINE_W-1:0]   fine_tgt,
  input  logic                elec_sel,
  input  logic                ext_sel,
  input  logic                pole8,
  input  logic                force_up,
  input  logic                force_dn,
  input  logic                cyc_sel,
  input  logic                comm_tick,
  input  logic                index_in,
  input  logic                zc_in,
  output logic                pump_up,
  output logic                pump_dn,
  output logic                cyc_out,
  output logic                lock_ok
);

  localparam int RW = COARSE_W + PRE_LOG2 + 2;
  localparam int PW = SAT_LOG2 + 1;
  localparam int LW = $clog2(LOCK_LIMIT + 1);
  localparam logic [PW-1:0] SAT = PW'(1) << SAT_LOG2;
  localparam logic [LW-1:0] LIM = LW'(LOCK_LIMIT);

  typedef enum logic [1:0] {PH_IDLE, PH_COARSE, PH_FINE, PH_DONE} phase_t;

  phase_t              phase;
  logic [COARSE_W-1:0] crs;
  logic [FINE_W-1:0]   fin;
  logic [PRE_LOG2-1:0] pre;
  logic [PW-1:0]       pw, upcnt, pw_load;
  logic [RW-1:0]       rem, rem_m1;
  logic [LW-1:0]       since;
  logic [2:0]          ecnt, ecnt_last;
  logic                idx_q, cyc_tgl, icyc, evt, loop_up, loop_dn;

  assign ecnt_last = pole8 ? 3'd3 : 3'd5;
  assign icyc      = comm_tick & (elec_sel | (ecnt >= ecnt_last));
  assign evt       = ext_sel ? (index_in & ~idx_q) : icyc;

  always_comb begin
    case (phase)
      PH_COARSE: rem = (RW'(crs) << PRE_LOG2) - RW'(pre) + RW'(fin);
      PH_FINE:   rem = RW'(fin);
      default:   rem = '0;
    endcase
  end

  assign rem_m1  = rem - RW'(1);
  assign pw_load = (rem == '0) ? '0 : ((rem_m1 > RW'(SAT)) ? SAT : PW'(rem_m1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      crs   <= '0;
      fin   <= '0;
      pre   <= '0;
      pw    <= '0;
      upcnt <= '0;
    end else if (evt) begin
      crs   <= coarse_tgt;
      fin   <= fine_tgt;
      pre   <= '0;
      upcnt <= '0;
      pw    <= pw_load;
      if (coarse_tgt != '0)    phase <= PH_COARSE;
      else if (fine_tgt != '0) phase <= PH_FINE;
      else                     phase <= PH_DONE;
    end else begin
      if (pw != '0) pw <= pw - PW'(1);
      case (phase)
        PH_COARSE: begin
          pre <= pre + PRE_LOG2'(1);
          if (&pre) begin
            crs <= crs - COARSE_W'(1);
            if (crs == COARSE_W'(1)) phase <= (fin != '0) ? PH_FINE : PH_DONE;
          end
        end
        PH_FINE: begin
          fin <= fin - FINE_W'(1);
          if (fin == FINE_W'(1)) phase <= PH_DONE;
        end
        PH_DONE: if (upcnt < SAT) upcnt <= upcnt + PW'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= 1'b0;
      ecnt    <= '0;
      cyc_tgl <= 1'b0;
      since   <= '0;
      lock_ok <= 1'b0;
    end else begin
      idx_q <= index_in;
      if (comm_tick) ecnt <= (ecnt >= ecnt_last) ? 3'd0 : ecnt + 3'd1;
      if (icyc) cyc_tgl <= ~cyc_tgl;
      if (evt) begin
        since   <= '0;
        lock_ok <= (since != LIM);
      end else begin
        if (since != LIM) since <= since + LW'(1);
        else              lock_ok <= 1'b0;
      end
    end
  end

  assign loop_up = (phase == PH_DONE) && (upcnt < SAT);
  assign loop_dn = (pw != '0) && (phase != PH_DONE);
  assign pump_up = force_up ? ~force_dn : (~force_dn & loop_up);
  assign pump_dn = force_dn ? ~force_up : (~force_up & loop_dn);
  assign cyc_out = cyc_sel ? cyc_tgl : zc_in;

  // R5
  up_dn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

  // R2
  dn_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && pw != '0) |=> (pw == $past(pw) - PW'(1)));

  // R4
  up_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE && !evt && upcnt < SAT) |=> (upcnt == $past(upcnt) + PW'(1)));

  // R10
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && since == LIM) |=> !lock_ok);

  // R7
  rev_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt <= 3'd5);

  // R8
  ext_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && !index_in && phase == PH_IDLE) |=> (phase == PH_IDLE));

endmodule

// File: tb/tb_spindle_fll.sv
`timescale 1ns/1ps
module tb_spindle_fll;
  localparam int PRE  = 2;
  localparam int SATL = 6;
  localparam int LIM  = 300;
  localparam int SATW = 1 << SATL;

  logic clk, rst_n;
  logic [11:0] coarse_tgt;
  logic [10:0] fine_tgt;
  logic elec_sel, ext_sel, pole8, force_up, force_dn, cyc_sel;
  logic comm_tick, index_in, zc_in;
  logic pump_up, pump_dn, cyc_out, lock_ok;

  spindle_fll #(.COARSE_W(12), .FINE_W(11), .PRE_LOG2(PRE), .SAT_LOG2(SATL),
                .LOCK_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .coarse_tgt(coarse_tgt), .fine_tgt(fine_tgt),
    .elec_sel(elec_sel), .ext_sel(ext_sel), .pole8(pole8), .force_up(force_up),
    .force_dn(force_dn), .cyc_sel(cyc_sel), .comm_tick(comm_tick),
    .index_in(index_in), .zc_in(zc_in), .pump_up(pump_up), .pump_dn(pump_dn),
    .cyc_out(cyc_out), .lock_ok(lock_ok));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0, tgt = 0, excl_bad = 0;
  bit started = 0, mon_on = 1, use_idx = 0;
  bit    q_up[$];
  int    q_w[$];
  string q_tag[$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int clip(int v);
    return (v > SATW) ? SATW : v;
  endfunction

  task automatic expect_pulse(bit up, int w, string tag);
    q_up.push_back(up); q_w.push_back(w); q_tag.push_back(tag);
  endtask

  task automatic push(int k, string tag);
    if (k < tgt) expect_pulse(1'b0, clip(tgt - k), tag);
    else if (k > tgt) expect_pulse(1'b1, clip(k - tgt), tag);
  endtask

  task automatic take(bit up, int w);
    if (q_up.size() == 0) chk(1'b0, "R2", "unexpected pulse width", w, 0);
    else begin
      bit eu = q_up.pop_front();
      int ew = q_w.pop_front();
      string t = q_tag.pop_front();
      chk(eu == up && ew == w, t, "pulse (negative = down)",
          up ? w : -w, eu ? ew : -ew);
    end
  endtask

  initial begin : monitor
    int ur, dr;
    ur = 0; dr = 0;
    forever begin
      @(negedge clk); #1;
      if (rst_n && pump_up && pump_dn) excl_bad++;
      if (!mon_on || !rst_n) begin ur = 0; dr = 0; end
      else begin
        if (pump_up) ur++;
        else if (ur != 0) begin take(1'b1, ur); ur = 0; end
        if (pump_dn) dr++;
        else if (dr != 0) begin take(1'b0, dr); dr = 0; end
      end
    end
  end

  task automatic set_target(int c, int f);
    coarse_tgt = 12'(c); fine_tgt = 11'(f); tgt = c * (1 << PRE) + f;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; comm_tick = 0; index_in = 0; force_up = 0; force_dn = 0; zc_in = 0;
    started = 0;
    chk(q_up.size() == 0, "R2", "expected pulses left over", q_up.size(), 0);
    q_up.delete(); q_w.delete(); q_tag.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic strobe_set(bit v);
    if (use_idx) index_in = v; else comm_tick = v;
  endtask

  task automatic strobe_first();
    @(negedge clk); strobe_set(1'b1);
    @(negedge clk); strobe_set(1'b0);
  endtask

  task automatic strobe_after(int k);
    repeat (k - 2) @(negedge clk);
    strobe_first();
  endtask

  task automatic ev_first();
    strobe_first(); started = 1;
  endtask

  task automatic ev(int k, string tag);
    push(k, tag); strobe_after(k);
  endtask

  task automatic mech_first(int n, int s);
    strobe_first();
    repeat (n - 1) strobe_after(s);
    started = 1;
  endtask

  task automatic mech_sample(int n, int s, string tag);
    push(n * s, tag);
    repeat (n) strobe_after(s);
  endtask

  task automatic idle_end(string tag);
    expect_pulse(1'b1, SATW, tag);
    repeat (tgt + SATW + 6) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : driver
    rst_n = 0; coarse_tgt = 0; fine_tgt = 0; elec_sel = 1; ext_sel = 0; pole8 = 1;
    force_up = 0; force_dn = 0; cyc_sel = 0; comm_tick = 0; index_in = 0; zc_in = 0;

    // R1 reset state, no pulse before first event
    set_target(3, 5);
    do_reset();
    repeat (30) @(negedge clk); #1;
    chk(pump_up == 0, "R1", "pump_up after reset", pump_up, 0);
    chk(pump_dn == 0, "R1", "pump_dn after reset", pump_dn, 0);
    chk(lock_ok == 0, "R1", "lock_ok after reset", lock_ok, 0);

    // R2 R3 R4 R6 electrical samples, T = 17
    ev_first();
    ev(12, "R2"); ev(17, "R2"); ev(25, "R3"); ev(10, "R6");
    ev(20, "R3"); ev(100, "R4");
    idle_end("R4");

    // R2 fine only, T = 9
    set_target(0, 9); do_reset();
    ev_first(); ev(5, "R2"); ev(12, "R3"); idle_end("R4");

    // R2 coarse only, T = 20
    set_target(5, 0); do_reset();
    ev_first(); ev(14, "R2"); ev(23, "R3"); idle_end("R4");

    // R4 saturated down, T = 165
    set_target(40, 5); do_reset();
    ev_first(); ev(20, "R4"); idle_end("R4");

    // R7 mechanical, 8 pole
    set_target(3, 5); elec_sel = 0; pole8 = 1; do_reset();
    mech_first(4, 3); mech_sample(4, 3, "R7"); mech_sample(4, 6, "R7"); idle_end("R7");

    // R7 mechanical, 12 pole
    pole8 = 0; do_reset();
    mech_first(6, 3); mech_sample(6, 3, "R7"); mech_sample(6, 2, "R7"); idle_end("R7");

    // R8 index feedback, comm_tick held high
    elec_sel = 1; pole8 = 1; ext_sel = 1; do_reset();
    @(negedge clk); comm_tick = 1; use_idx = 1;
    ev_first(); ev(12, "R8"); ev(25, "R8"); idle_end("R8");
    use_idx = 0; ext_sel = 0;

    // R10 lock flag boundary
    do_reset();
    ev_first(); #1;
    chk(lock_ok == 1, "R10", "lock after first short sample", lock_ok, 1);
    ev(300, "R4"); #1;
    chk(lock_ok == 1, "R10", "lock at interval == limit", lock_ok, 1);
    ev(301, "R4"); #1;
    chk(lock_ok == 0, "R10", "lock at interval == limit+1", lock_ok, 0);
    ev(20, "R3"); #1;
    chk(lock_ok == 1, "R10", "lock regained", lock_ok, 1);
    idle_end("R4");
    repeat (250) @(negedge clk); #1;
    chk(lock_ok == 0, "R10", "lock lost after long idle", lock_ok, 0);

    // R11 cycle output
    mon_on = 0; cyc_sel = 1; elec_sel = 1; do_reset(); #1;
    chk(cyc_out == 0, "R11", "cycle toggle after reset", cyc_out, 0);
    strobe_first(); #1;
    chk(cyc_out == 1, "R11", "cycle toggle after tick", cyc_out, 1);
    strobe_after(3); #1;
    chk(cyc_out == 0, "R11", "cycle toggle after second tick", cyc_out, 0);
    elec_sel = 0; pole8 = 1; do_reset();
    strobe_first(); strobe_after(3); strobe_after(3); #1;
    chk(cyc_out == 0, "R11", "mechanical toggle after 3 ticks", cyc_out, 0);
    strobe_after(3); #1;
    chk(cyc_out == 1, "R11", "mechanical toggle after 4 ticks", cyc_out, 1);
    @(negedge clk); cyc_sel = 0; zc_in = 1; #1;
    chk(cyc_out == 1, "R11", "raw zero-crossing high", cyc_out, 1);
    @(negedge clk); zc_in = 0; #1;
    chk(cyc_out == 0, "R11", "raw zero-crossing low", cyc_out, 0);

    // R9 overrides
    elec_sel = 1; set_target(3, 5); do_reset();
    @(negedge clk); force_up = 1; #1;
    chk(pump_up == 1 && pump_dn == 0, "R9", "force_up {up,dn}", {pump_up, pump_dn}, 2);
    @(negedge clk); force_up = 0; force_dn = 1; #1;
    chk(pump_up == 0 && pump_dn == 1, "R9", "force_dn {up,dn}", {pump_up, pump_dn}, 1);
    @(negedge clk); force_dn = 0;
    strobe_first();
    repeat (tgt + 3) @(negedge clk); #1;
    chk(pump_up == 1, "R3", "loop up after target expiry", pump_up, 1);
    @(negedge clk); force_dn = 1; #1;
    chk(pump_up == 0 && pump_dn == 1, "R9", "force_dn over loop up", {pump_up, pump_dn}, 1);
    @(negedge clk); force_up = 1; #1;
    chk(pump_up == 0 && pump_dn == 0, "R9", "both forces", {pump_up, pump_dn}, 0);
    @(negedge clk); force_up = 0; force_dn = 0; #1;
    chk(pump_up == 1, "R9", "loop resumes", pump_up, 1);

    chk(excl_bad == 0, "R5", "cycles with both pump outputs high", excl_bad, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule